// File: doc/BRIEF.md
# Monitor Channel Transmit Timeout Controller

This block drives the sending side of a byte-wide monitor channel that rides in a frame-synchronous serial TDM link. Two handshake bits govern the channel. The sender drives MX and the receiver answers on MR. A host writes bytes into a one-byte holding register. The block places each byte on the channel by pulling MX low for one frame. It then waits for the receiver to acknowledge by pulling MR low.

A frame-counting watchdog guards every wait, whether the wait is for the remote acknowledge or for the host's next byte. If the watchdog is enabled and the awaited event does not arrive within a fixed number of frames, the transfer is abandoned. The block reports the abort and ends the message by keeping MX high for two further frames, then returns to idle. All state advances only on the frame strobe. Serialisation into the TDM frame and the receive side belong to neighbouring logic.

Top module: `mon_tx_timeout`

## Requirements
- R1: After reset mx_out is 1, tx_byte is 0x00, and abort_pulse and done_pulse are 0.
- R2: The outputs change only on a clock edge where frame_tick is 1. A host write (host_valid=1) is captured in any cycle into a one-byte holding register, and a later write replaces an earlier one that has not yet been sent.
- R3: At a strobe in the idle or awaiting-host state with a held byte, the byte appears on tx_byte and mx_out goes to 0 for exactly one frame. At the next strobe mx_out returns to 1 and the block awaits the acknowledge.
- R4: When mr_in is 0 at a strobe while the block awaits the acknowledge, done_pulse is 1 for one clock and the block awaits the next host byte. The value of mr_in is ignored in the frame in which MX is low.
- R5: With tout_en=1, abort_pulse is 1 for one clock at the 40th consecutive strobe that awaits the acknowledge with mr_in=1.
- R6: With tout_en=1, abort_pulse is 1 for one clock at the 40th consecutive strobe that awaits a host byte with none held.
- R7: The frame count restarts from zero at the start of every wait, so frames spent in an earlier wait never shorten a later one.
- R8: After an abort, mx_out stays 1 for the next two strobes (end of message). A byte held meanwhile is placed on the channel only at the third strobe after the abort.
- R9: With tout_en=0 no wait ever expires, and abort_pulse stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | One-clock strobe marking each TDM frame |
| mr_in | input | 1 | Received MR handshake bit (0 = acknowledge) |
| host_valid | input | 1 | Host write strobe for host_byte |
| host_byte | input | 8 | Byte written by the host |
| tout_en | input | 1 | Enables the frame-counting watchdog |
| mx_out | output | 1 | Transmitted MX handshake bit |
| tx_byte | output | 8 | Byte currently placed on the channel |
| abort_pulse | output | 1 | One-clock flag: watchdog expired |
| done_pulse | output | 1 | One-clock flag: byte acknowledged |

## Verification
The hardest condition to reach from the ports is the exact expiry boundary. The watchdog must stay silent at the 39th waiting strobe and fire at the 40th, and that count must restart when the wait changes from awaiting the host to awaiting the acknowledge. The stimulus gets there by holding the block in the awaiting-host wait for 35 frames and then supplying a byte. It then withholds the acknowledge and checks abort_pulse at every strobe, so a count carried over from the first wait would fire early. A byte written during the end-of-message frames shows that the two-frame tail is honoured before the channel is reused.

// File: rtl/mon_tx_pkg.sv
package mon_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_SEND      = 3'd1,
        ST_WAIT_ACK  = 3'd2,
        ST_WAIT_HOST = 3'd3,
        ST_EOM       = 3'd4
    } tx_state_e;
endpackage

// File: rtl/mon_tx_hold.sv
module mon_tx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic         vld,
    output logic [W-1:0] data
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] data;
    } hold_t;

    hold_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (take)
            r_d.vld = 1'b0;
        if (wr_en) begin
            r_d.vld  = 1'b1;
            r_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign vld  = r_q.vld;
    assign data = r_q.data;

    // R2: a write always leaves the register holding a byte
    p_write_sets_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld);
endmodule

// File: rtl/mon_tx_wdog.sv
module mon_tx_wdog #(
    parameter int LIMIT = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic active,
    input  logic hit,
    output logic expire
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign expire = active && tick && !hit && (cnt_q == CNT_W'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!active || expire)
            cnt_d = '0;
        else if (tick)
            cnt_d = hit ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5/R6: the count never reaches the limit itself
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(LIMIT));
    // R7: an idle watchdog holds a zero count
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt_q == '0));
endmodule

// File: rtl/mon_tx_timeout.sv
module mon_tx_timeout
    import mon_tx_pkg::*;
#(
    parameter int W          = 8,
    parameter int LIMIT      = 40,
    parameter int EOM_FRAMES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_tick,
    input  logic         mr_in,
    input  logic         host_valid,
    input  logic [W-1:0] host_byte,
    input  logic         tout_en,
    output logic         mx_out,
    output logic [W-1:0] tx_byte,
    output logic         abort_pulse,
    output logic         done_pulse
);
    localparam int EOM_W = $clog2(EOM_FRAMES + 1);

    typedef struct packed {
        tx_state_e        state;
        logic             mx;
        logic [W-1:0]     data;
        logic             done;
        logic             abort;
        logic [EOM_W-1:0] eom_cnt;
    } ctl_t;

    ctl_t c_d, c_q;

    logic         hold_vld;
    logic [W-1:0] hold_data;
    logic         take;
    logic         wd_active;
    logic         wd_hit;
    logic         wd_expire;

    mon_tx_hold #(.W(W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_valid),
        .wr_data (host_byte),
        .take    (take),
        .vld     (hold_vld),
        .data    (hold_data)
    );

    assign wd_active = tout_en &&
                       ((c_q.state == ST_WAIT_ACK) || (c_q.state == ST_WAIT_HOST));
    assign wd_hit    = (c_q.state == ST_WAIT_ACK) ? !mr_in : hold_vld;

    mon_tx_wdog #(.LIMIT(LIMIT)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (frame_tick),
        .active (wd_active),
        .hit    (wd_hit),
        .expire (wd_expire)
    );

    always_comb begin
        c_d       = c_q;
        c_d.done  = 1'b0;
        c_d.abort = 1'b0;
        take      = 1'b0;
        if (frame_tick) begin
            case (c_q.state)
                ST_IDLE: begin
                    if (hold_vld) begin
                        c_d.state = ST_SEND;
                        c_d.mx    = 1'b0;
                        c_d.data  = hold_data;
                        take      = 1'b1;
                    end
                end
                ST_SEND: begin
                    c_d.state = ST_WAIT_ACK;
                    c_d.mx    = 1'b1;
                end
                ST_WAIT_ACK: begin
                    if (!mr_in) begin
                        c_d.state = ST_WAIT_HOST;
                        c_d.done  = 1'b1;
                    end else if (wd_expire) begin
                        c_d.state   = ST_EOM;
                        c_d.abort   = 1'b1;
                        c_d.eom_cnt = '0;
                    end
                end
                ST_WAIT_HOST: begin
                    if (hold_vld) begin
                        c_d.state = ST_SEND;
                        c_d.mx    = 1'b0;
                        c_d.data  = hold_data;
                        take      = 1'b1;
                    end else if (wd_expire) begin
                        c_d.state   = ST_EOM;
                        c_d.abort   = 1'b1;
                        c_d.eom_cnt = '0;
                    end
                end
                ST_EOM: begin
                    c_d.mx = 1'b1;
                    if (c_q.eom_cnt == EOM_W'(EOM_FRAMES - 1))
                        c_d.state = ST_IDLE;
                    else
                        c_d.eom_cnt = c_q.eom_cnt + 1'b1;
                end
                default: begin
                    c_d.state = ST_IDLE;
                    c_d.mx    = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_IDLE;
            c_q.mx    <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign mx_out      = c_q.mx;
    assign tx_byte     = c_q.data;
    assign abort_pulse = c_q.abort;
    assign done_pulse  = c_q.done;

    // R2: nothing on the channel moves between strobes
    p_frame_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> ($stable(mx_out) && $stable(tx_byte)));
    // R3: MX is low for a single frame only
    p_mx_low_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mx_out && frame_tick) |=> mx_out);
    // R4: acknowledge and abort never flag together
    p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_pulse, abort_pulse}));
    // R8: MX is high throughout the end-of-message tail
    p_eom_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_EOM) |-> mx_out);
    // R9: an abort needs the watchdog enabled at the strobe before
    p_abort_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> ($past(tout_en) && $past(frame_tick)));
endmodule

// File: tb/mon_tx_timeout_bench.sv
module mon_tx_timeout_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_tick = 1'b0;
    logic       mr_in = 1'b1;
    logic       host_valid = 1'b0;
    logic [7:0] host_byte = 8'h00;
    logic       tout_en = 1'b1;
    logic       mx_out;
    logic [7:0] tx_byte;
    logic       abort_pulse;
    logic       done_pulse;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #2.5 clk = ~clk;

    mon_tx_timeout u_mon_tx_timeout (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_tick  (frame_tick),
        .mr_in       (mr_in),
        .host_valid  (host_valid),
        .host_byte   (host_byte),
        .tout_en     (tout_en),
        .mx_out      (mx_out),
        .tx_byte     (tx_byte),
        .abort_pulse (abort_pulse),
        .done_pulse  (done_pulse)
    );

    // {hv, hb[7:0], mr, exp_mx, exp_byte[7:0], exp_done}, tout_en = 1
    localparam logic [19:0] VEC [0:9] = '{
        {1'b1, 8'hA5, 1'b1, 1'b0, 8'hA5, 1'b0},
        {1'b0, 8'h00, 1'b1, 1'b1, 8'hA5, 1'b0},
        {1'b0, 8'h00, 1'b1, 1'b1, 8'hA5, 1'b0},
        {1'b0, 8'h00, 1'b0, 1'b1, 8'hA5, 1'b1},
        {1'b1, 8'h3C, 1'b1, 1'b0, 8'h3C, 1'b0},
        {1'b0, 8'h00, 1'b0, 1'b1, 8'h3C, 1'b0},
        {1'b0, 8'h00, 1'b0, 1'b1, 8'h3C, 1'b1},
        {1'b1, 8'hFF, 1'b1, 1'b0, 8'hFF, 1'b0},
        {1'b0, 8'h00, 1'b1, 1'b1, 8'hFF, 1'b0},
        {1'b0, 8'h00, 1'b0, 1'b1, 8'hFF, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_frame(input logic hv, input logic [7:0] hb,
                            input logic mr, input logic ten);
        @(negedge clk);
        host_valid = hv;
        host_byte  = hb;
        @(negedge clk);
        host_valid = 1'b0;
        mr_in      = mr;
        tout_en    = ten;
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        // R1: reset values
        repeat (3) @(negedge clk);
        chk("R1 mx", mx_out, 1);
        chk("R1 byte", tx_byte, 8'h00);
        chk("R1 flags", {abort_pulse, done_pulse}, 0);
        rst_n = 1'b1;
        // R2: a write with no strobe leaves the channel untouched
        @(negedge clk);
        host_valid = 1'b1; host_byte = 8'h5A;
        @(negedge clk);
        host_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 no strobe mx", mx_out, 1);
        chk("R2 no strobe byte", tx_byte, 8'h00);

        // Table: R3 send, R4 acknowledge, R2 latest write kept (A5 over 5A)
        for (int i = 0; i < 10; i++) begin
            do_frame(VEC[i][19], VEC[i][18:11], VEC[i][10], 1'b1);
            chk("R3 mx", mx_out, VEC[i][9]);
            chk("R3 byte", tx_byte, VEC[i][8:1]);
            chk("R4 done", done_pulse, VEC[i][0]);
            chk("R4 abort", abort_pulse, 0);
        end

        // R6: host wait expires at the 40th strobe
        for (int i = 0; i < 39; i++) begin
            do_frame(1'b0, 8'h00, 1'b1, 1'b1);
            chk("R6 early", abort_pulse, 0);
        end
        do_frame(1'b0, 8'h00, 1'b1, 1'b1);
        chk("R6 expiry", abort_pulse, 1);
        chk("R6 mx", mx_out, 1);

        // R8: two-frame end-of-message tail, byte written during it waits
        do_frame(1'b1, 8'h11, 1'b1, 1'b1);
        chk("R8 tail1 mx", mx_out, 1);
        chk("R8 tail1 abort", abort_pulse, 0);
        do_frame(1'b0, 8'h00, 1'b1, 1'b1);
        chk("R8 tail2 mx", mx_out, 1);
        do_frame(1'b0, 8'h00, 1'b1, 1'b1);
        chk("R8 third mx", mx_out, 0);
        chk("R8 third byte", tx_byte, 8'h11);

        // R5: acknowledge wait expires at the 40th strobe; R4 MR ignored in send frame
        do_frame(1'b0, 8'h00, 1'b1, 1'b1);
        chk("R4 to wait", mx_out, 1);
        for (int i = 0; i < 39; i++) begin
            do_frame(1'b0, 8'h00, 1'b1, 1'b1);
            chk("R5 early", abort_pulse, 0);
        end
        do_frame(1'b0, 8'h00, 1'b1, 1'b1);
        chk("R5 expiry", abort_pulse, 1);
        do_frame(1'b0, 8'h00, 1'b1, 1'b1);
        do_frame(1'b0, 8'h00, 1'b1, 1'b1);

        // R9: disabled watchdog never expires
        do_frame(1'b1, 8'h22, 1'b1, 1'b0);
        chk("R9 send", tx_byte, 8'h22);
        do_frame(1'b0, 8'h00, 1'b1, 1'b0);
        for (int i = 0; i < 100; i++) begin
            do_frame(1'b0, 8'h00, 1'b1, 1'b0);
            chk("R9 no abort", abort_pulse, 0);
        end
        chk("R9 mx", mx_out, 1);
        do_frame(1'b0, 8'h00, 1'b0, 1'b0);
        chk("R9 late ack done", done_pulse, 1);

        // R7: count restarts after a partial host wait
        for (int i = 0; i < 35; i++) begin
            do_frame(1'b0, 8'h00, 1'b1, 1'b1);
            chk("R7 host wait", abort_pulse, 0);
        end
        do_frame(1'b1, 8'h33, 1'b1, 1'b1);
        chk("R7 send mx", mx_out, 0);
        chk("R7 send byte", tx_byte, 8'h33);
        do_frame(1'b0, 8'h00, 1'b1, 1'b1);
        for (int i = 0; i < 39; i++) begin
            do_frame(1'b0, 8'h00, 1'b1, 1'b1);
            chk("R7 fresh count", abort_pulse, 0);
        end
        do_frame(1'b0, 8'h00, 1'b1, 1'b1);
        chk("R7 expiry", abort_pulse, 1);

        finish_run();
    end
endmodule